// File: doc/BRIEF.md
# Two-Level Interrupt Save/Restore Unit

This block owns the machine-state word of a small processor core and three save/restore register pairs, one for each interrupt class: noncritical, critical and machine check. When the core raises a request that its class enable allows, the unit records a return address and the current machine-state word in that class's own pair. It then clears the enable bits that would let an equal or lower class re-enter, and reports which class was taken so that the core can select a handler vector.

Each class has a return strobe. The strobe restores the machine-state word from its pair and hands the saved address back to the core as a resume target. The three pairs are independent. A critical interrupt can therefore preempt a running noncritical handler without touching the noncritical pair, and a machine check can preempt either. The core may also load the machine-state word directly. Instruction fetch, vector tables and pipeline flushing belong to the surrounding core.

Top module: `irq_save_unit`

## Requirements
- R1: While reset is asserted and after it is released, the machine-state word, all six save registers, `irq_taken`, `taken_cls`, `ret_valid` and `ret_pc` are zero.
- R2: A noncritical request with the external-enable bit (bit 15) set is taken at the next clock. `irq_taken` becomes 3'b001 and `taken_cls` becomes 1. The noncritical pair receives the return address and the previous machine-state word. Only bit 15 of the word is cleared.
- R3: A critical request with the critical-enable bit (bit 17) set is taken at the next clock. `irq_taken` becomes 3'b010 and `taken_cls` becomes 2. The critical pair is loaded. Bits 17 and 15 are cleared.
- R4: A machine-check request with the machine-check-enable bit (bit 12) set is taken at the next clock. `irq_taken` becomes 3'b100 and `taken_cls` becomes 3. The machine-check pair is loaded. Bits 12, 17 and 15 are cleared.
- R5: When several enabled requests arrive in one cycle, only one is taken. Machine check takes precedence over critical, and critical over noncritical. `irq_taken` is one-hot or zero.
- R6: A request whose enable bit is clear leaves the machine-state word and all save registers unchanged, and `irq_taken` stays zero.
- R7: The saved address is `fault_pc` when the request's use-fault flag is 1 and `next_pc` when it is 0.
- R8: Taking a critical or machine-check interrupt leaves the noncritical pair unchanged.
- R9: A return strobe (`ret_nc`, `ret_cr` or `ret_mc`) loads the machine-state word from its class's saved word. One clock later it puts the saved address on `ret_pc` with a one-cycle `ret_valid` pulse.
- R10: Interrupt entry takes precedence over any return strobe, and a return takes precedence over a direct write. Among simultaneous return strobes, machine check wins over critical, and critical over noncritical. A strobe that loses has no effect.
- R11: When no interrupt is taken and no return occurs, `msw_wr_en` loads `msw_wr_data` into the machine-state word at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nc_req | input | 1 | Noncritical interrupt request |
| nc_use_fault | input | 1 | Noncritical: save fault_pc (1) or next_pc (0) |
| cr_req | input | 1 | Critical interrupt request |
| cr_use_fault | input | 1 | Critical: address select |
| mc_req | input | 1 | Machine-check request |
| mc_use_fault | input | 1 | Machine check: address select |
| next_pc | input | AW | Address of the next instruction |
| fault_pc | input | AW | Address of the excepting instruction |
| msw_wr_en | input | 1 | Direct write of the machine-state word |
| msw_wr_data | input | MW | Value for a direct write |
| ret_nc | input | 1 | Return from noncritical handler |
| ret_cr | input | 1 | Return from critical handler |
| ret_mc | input | 1 | Return from machine-check handler |
| msw | output | MW | Current machine-state word |
| irq_taken | output | 3 | One-hot taken pulse {mc, cr, nc} |
| taken_cls | output | 2 | Taken class code: 0 none, 1 nc, 2 cr, 3 mc |
| ret_valid | output | 1 | Pulse: ret_pc holds a restored address |
| ret_pc | output | AW | Address restored by the last return |
| nc_save_addr | output | AW | Noncritical saved address |
| nc_save_msw | output | MW | Noncritical saved machine-state word |
| cr_save_addr | output | AW | Critical saved address |
| cr_save_msw | output | MW | Critical saved machine-state word |
| mc_save_addr | output | AW | Machine-check saved address |
| mc_save_msw | output | MW | Machine-check saved machine-state word |

## Verification
The clocked properties compare each output with the previous cycle's inputs and state. They rely on every request, flag, strobe and address input carrying a known value on every clock edge after reset, and on requests and strobes being low while reset is held. The stimulus meets this by changing every input on the falling edge, driving all inputs to zero before and during reset, and returning each input to zero on idle cycles. Random phases draw only from a deterministic shift register, so every input stays defined.

// File: rtl/irq_save_pkg.sv
package irq_save_pkg;

    localparam int NCLS  = 3;
    localparam int CLS_W = $clog2(NCLS + 1);

    localparam int IDX_NC = 0;
    localparam int IDX_CR = 1;
    localparam int IDX_MC = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_NONE = 2'd0,
        CLS_NC   = 2'd1,
        CLS_CR   = 2'd2,
        CLS_MC   = 2'd3
    } irq_cls_e;

endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] en,
    output logic [N-1:0] grant
);

    // Highest index wins among requests whose enable is set.
    always_comb begin
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i] && en[i] && (grant == '0)) begin
                grant[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_save_pair.sv
module irq_save_pair #(
    parameter int AW = 32,
    parameter int MW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_en,
    input  logic [AW-1:0] save_addr,
    input  logic [MW-1:0] save_msw,
    output logic [AW-1:0] held_addr,
    output logic [MW-1:0] held_msw
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [MW-1:0] msw;
    } pair_t;

    pair_t pair_d, pair_q;

    always_comb begin
        pair_d = pair_q;
        if (save_en) begin
            pair_d.addr = save_addr;
            pair_d.msw  = save_msw;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_q <= '0;
        end else begin
            pair_q <= pair_d;
        end
    end

    assign held_addr = pair_q.addr;
    assign held_msw  = pair_q.msw;

endmodule

// File: rtl/irq_save_unit.sv
module irq_save_unit
    import irq_save_pkg::*;
#(
    parameter int AW          = 32,
    parameter int MW          = 32,
    parameter int EXT_EN_BIT  = 15,
    parameter int CRIT_EN_BIT = 17,
    parameter int MCHK_EN_BIT = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nc_req,
    input  logic          nc_use_fault,
    input  logic          cr_req,
    input  logic          cr_use_fault,
    input  logic          mc_req,
    input  logic          mc_use_fault,
    input  logic [AW-1:0] next_pc,
    input  logic [AW-1:0] fault_pc,
    input  logic          msw_wr_en,
    input  logic [MW-1:0] msw_wr_data,
    input  logic          ret_nc,
    input  logic          ret_cr,
    input  logic          ret_mc,
    output logic [MW-1:0] msw,
    output logic [2:0]    irq_taken,
    output logic [1:0]    taken_cls,
    output logic          ret_valid,
    output logic [AW-1:0] ret_pc,
    output logic [AW-1:0] nc_save_addr,
    output logic [MW-1:0] nc_save_msw,
    output logic [AW-1:0] cr_save_addr,
    output logic [MW-1:0] cr_save_msw,
    output logic [AW-1:0] mc_save_addr,
    output logic [MW-1:0] mc_save_msw
);

    typedef struct packed {
        logic [MW-1:0]    msw;
        logic [NCLS-1:0]  taken;
        logic [CLS_W-1:0] cls;
        logic             ret_valid;
        logic [AW-1:0]    ret_pc;
    } state_t;

    function automatic int en_bit(input int cls_idx);
        case (cls_idx)
            IDX_NC:  return EXT_EN_BIT;
            IDX_CR:  return CRIT_EN_BIT;
            default: return MCHK_EN_BIT;
        endcase
    endfunction

    state_t st_d, st_q;

    logic [NCLS-1:0] req_vec, fault_sel, en_vec, ret_vec;
    logic [NCLS-1:0] take_grant, ret_grant;
    logic            any_take, any_ret;
    logic [AW-1:0]   save_addr [NCLS];
    logic [AW-1:0]   held_addr [NCLS];
    logic [MW-1:0]   held_msw  [NCLS];

    assign req_vec   = {mc_req, cr_req, nc_req};
    assign fault_sel = {mc_use_fault, cr_use_fault, nc_use_fault};
    assign ret_vec   = {ret_mc, ret_cr, ret_nc};

    always_comb begin
        for (int i = 0; i < NCLS; i++) begin
            en_vec[i] = st_q.msw[en_bit(i)];
        end
    end

    irq_prio_arb #(.N(NCLS)) u_take_arb (
        .req   (req_vec),
        .en    (en_vec),
        .grant (take_grant)
    );

    irq_prio_arb #(.N(NCLS)) u_ret_arb (
        .req   (ret_vec),
        .en    ({NCLS{1'b1}}),
        .grant (ret_grant)
    );

    assign any_take = |take_grant;
    assign any_ret  = |ret_grant;

    generate
        for (genvar g = 0; g < NCLS; g++) begin : g_pair
            assign save_addr[g] = fault_sel[g] ? fault_pc : next_pc;

            irq_save_pair #(.AW(AW), .MW(MW)) u_pair (
                .clk       (clk),
                .rst_n     (rst_n),
                .save_en   (take_grant[g]),
                .save_addr (save_addr[g]),
                .save_msw  (st_q.msw),
                .held_addr (held_addr[g]),
                .held_msw  (held_msw[g])
            );
        end
    endgenerate

    always_comb begin
        st_d           = st_q;
        st_d.taken     = take_grant;
        st_d.cls       = CLS_NONE;
        st_d.ret_valid = 1'b0;
        if (any_take) begin
            for (int i = 0; i < NCLS; i++) begin
                if (take_grant[i]) begin
                    st_d.cls = CLS_W'(i + 1);
                    for (int j = 0; j <= i; j++) begin
                        st_d.msw[en_bit(j)] = 1'b0;
                    end
                end
            end
        end else if (any_ret) begin
            for (int i = 0; i < NCLS; i++) begin
                if (ret_grant[i]) begin
                    st_d.msw    = held_msw[i];
                    st_d.ret_pc = held_addr[i];
                end
            end
            st_d.ret_valid = 1'b1;
        end else if (msw_wr_en) begin
            st_d.msw = msw_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign msw          = st_q.msw;
    assign irq_taken    = st_q.taken;
    assign taken_cls    = st_q.cls;
    assign ret_valid    = st_q.ret_valid;
    assign ret_pc       = st_q.ret_pc;
    assign nc_save_addr = held_addr[IDX_NC];
    assign nc_save_msw  = held_msw[IDX_NC];
    assign cr_save_addr = held_addr[IDX_CR];
    assign cr_save_msw  = held_msw[IDX_CR];
    assign mc_save_addr = held_addr[IDX_MC];
    assign mc_save_msw  = held_msw[IDX_MC];

    AST_TAKEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_taken)); // R5

    AST_NC_CLEARS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken[IDX_NC] |=> !msw[EXT_EN_BIT] || $past(any_ret || msw_wr_en)); // R2

    AST_NC_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (nc_req && !msw[EXT_EN_BIT]) |=> !irq_taken[IDX_NC]); // R6

    AST_CR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken[IDX_CR] |-> (!msw[CRIT_EN_BIT] && !msw[EXT_EN_BIT])); // R3

    AST_MC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken[IDX_MC] |-> (!msw[MCHK_EN_BIT] && !msw[CRIT_EN_BIT] && !msw[EXT_EN_BIT])); // R4

    AST_MC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (mc_req && msw[MCHK_EN_BIT]) |=> (irq_taken == 3'b100)); // R5

    AST_NC_PAIR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_req || mc_req) && !nc_req |=> $stable(nc_save_addr) && $stable(nc_save_msw)); // R8

    AST_NC_ADDR_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (nc_req && msw[EXT_EN_BIT] && !(cr_req && msw[CRIT_EN_BIT]) && !(mc_req && msw[MCHK_EN_BIT]))
        |=> nc_save_addr == (($past(nc_use_fault)) ? $past(fault_pc) : $past(next_pc))); // R7

    AST_NC_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_nc && !ret_cr && !ret_mc && !any_take)
        |=> (msw == $past(nc_save_msw)) && (ret_pc == $past(nc_save_addr)) && ret_valid); // R9

    AST_TAKE_BLOCKS_RET: assert property (@(posedge clk) disable iff (!rst_n)
        any_take |=> !ret_valid); // R10

endmodule

// File: tb/irq_save_unit_bench.sv
module irq_save_unit_bench;

    localparam int CLK_P = 10;

    typedef struct packed {
        logic [31:0]      msw;
        logic [2:0]       taken;
        logic [1:0]       cls;
        logic             rv;
        logic [31:0]      rpc;
        logic [5:0][31:0] save;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nc_req = 0, nc_use_fault = 0, cr_req = 0, cr_use_fault = 0;
    logic        mc_req = 0, mc_use_fault = 0;
    logic [31:0] next_pc = '0, fault_pc = '0;
    logic        msw_wr_en = 0;
    logic [31:0] msw_wr_data = '0;
    logic        ret_nc = 0, ret_cr = 0, ret_mc = 0;
    logic [31:0] msw, ret_pc;
    logic [2:0]  irq_taken;
    logic [1:0]  taken_cls;
    logic        ret_valid;
    logic [31:0] nc_save_addr, nc_save_msw, cr_save_addr, cr_save_msw;
    logic [31:0] mc_save_addr, mc_save_msw;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    exp_t  exp_q [$];
    string tag_q [$];

    logic [31:0] m_msw = '0;
    logic [31:0] m_rpc = '0;
    logic [31:0] m_addr [3];
    logic [31:0] m_sw   [3];

    always #(CLK_P / 2) clk = ~clk;

    irq_save_unit u_irq_save_unit (
        .clk(clk), .rst_n(rst_n),
        .nc_req(nc_req), .nc_use_fault(nc_use_fault),
        .cr_req(cr_req), .cr_use_fault(cr_use_fault),
        .mc_req(mc_req), .mc_use_fault(mc_use_fault),
        .next_pc(next_pc), .fault_pc(fault_pc),
        .msw_wr_en(msw_wr_en), .msw_wr_data(msw_wr_data),
        .ret_nc(ret_nc), .ret_cr(ret_cr), .ret_mc(ret_mc),
        .msw(msw), .irq_taken(irq_taken), .taken_cls(taken_cls),
        .ret_valid(ret_valid), .ret_pc(ret_pc),
        .nc_save_addr(nc_save_addr), .nc_save_msw(nc_save_msw),
        .cr_save_addr(cr_save_addr), .cr_save_msw(cr_save_msw),
        .mc_save_addr(mc_save_addr), .mc_save_msw(mc_save_msw)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int en_pos(input int c);
        return (c == 0) ? 15 : (c == 1) ? 17 : 12;
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected result.
    task automatic step(input logic [2:0] rq, input logic [2:0] uf,
                        input logic [31:0] npc, input logic [31:0] fpc,
                        input logic [2:0] rt, input logic wr,
                        input logic [31:0] wd, input string tag);
        exp_t e;
        int   g;
        int   r;
        @(negedge clk);
        {mc_req, cr_req, nc_req}                   = rq;
        {mc_use_fault, cr_use_fault, nc_use_fault} = uf;
        {ret_mc, ret_cr, ret_nc}                   = rt;
        next_pc = npc; fault_pc = fpc;
        msw_wr_en = wr; msw_wr_data = wd;
        g = -1;
        r = -1;
        for (int i = 2; i >= 0; i--) begin
            if (g < 0 && rq[i] && m_msw[en_pos(i)]) g = i;
            if (r < 0 && rt[i]) r = i;
        end
        e.taken = 3'b000;
        e.cls   = 2'd0;
        e.rv    = 1'b0;
        if (g >= 0) begin
            m_addr[g] = uf[g] ? fpc : npc;
            m_sw[g]   = m_msw;
            for (int j = 0; j <= g; j++) m_msw[en_pos(j)] = 1'b0;
            e.taken = 3'(1 << g);
            e.cls   = 2'(g + 1);
        end else if (r >= 0) begin
            m_msw = m_sw[r];
            m_rpc = m_addr[r];
            e.rv  = 1'b1;
        end else if (wr) begin
            m_msw = wd;
        end
        e.msw = m_msw;
        e.rpc = m_rpc;
        for (int i = 0; i < 3; i++) begin
            e.save[2*i]   = m_addr[i];
            e.save[2*i+1] = m_sw[i];
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(3'b000, 3'b000, '0, '0, 3'b000, 1'b0, '0, tag);
    endtask

    // Monitor: pops one expected item per cycle once the edge has settled.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P / 4);
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, "msw", msw, e.msw);
                check(t, "irq_taken", {29'd0, irq_taken}, {29'd0, e.taken});
                check(t, "taken_cls", {30'd0, taken_cls}, {30'd0, e.cls});
                check(t, "ret_valid", {31'd0, ret_valid}, {31'd0, e.rv});
                check(t, "ret_pc", ret_pc, e.rpc);
                check(t, "nc_save_addr", nc_save_addr, e.save[0]);
                check(t, "nc_save_msw", nc_save_msw, e.save[1]);
                check(t, "cr_save_addr", cr_save_addr, e.save[2]);
                check(t, "cr_save_msw", cr_save_msw, e.save[3]);
                check(t, "mc_save_addr", mc_save_addr, e.save[4]);
                check(t, "mc_save_msw", mc_save_msw, e.save[5]);
            end
        end
    end

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    localparam logic [31:0] ALL_EN = 32'h0002_9005;

    initial begin
        logic [31:0] lf;
        for (int i = 0; i < 3; i++) begin
            m_addr[i] = '0;
            m_sw[i]   = '0;
        end
        repeat (3) @(posedge clk);
        #(CLK_P / 4);
        // R1: state while reset is held
        check("R1", "msw in reset", msw, 32'h0);
        check("R1", "taken in reset", {29'd0, irq_taken}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #(CLK_P / 4);
        // R1: state after release
        check("R1", "ret_pc after reset", ret_pc, 32'h0);
        check("R1", "ret_valid after reset", {31'd0, ret_valid}, 32'h0);
        check("R1", "nc_save_addr after reset", nc_save_addr, 32'h0);
        check("R1", "mc_save_msw after reset", mc_save_msw, 32'h0);

        // R6: every class masked while all enables are clear
        step(3'b001, 3'b000, 32'h10, 32'h0C, 3'b000, 1'b0, '0, "R6");
        step(3'b010, 3'b000, 32'h20, 32'h1C, 3'b000, 1'b0, '0, "R6");
        step(3'b100, 3'b000, 32'h30, 32'h2C, 3'b000, 1'b0, '0, "R6");
        // R11: direct write enables all three classes
        step(3'b000, 3'b000, '0, '0, 3'b000, 1'b1, ALL_EN, "R11");
        // R2 and R7: noncritical entry saving next_pc
        step(3'b001, 3'b000, 32'h100, 32'h0FC, 3'b000, 1'b0, '0, "R2");
        // R6: held noncritical request is masked by the cleared enable
        step(3'b001, 3'b000, 32'h104, 32'h100, 3'b000, 1'b0, '0, "R6");
        // R3, R7, R8: critical preempts the noncritical handler, saves fault_pc
        step(3'b010, 3'b010, 32'h208, 32'h200, 3'b000, 1'b0, '0, "R8");
        idle("R8");
        // R9: return from critical, then from noncritical
        step(3'b000, 3'b000, '0, '0, 3'b010, 1'b0, '0, "R9");
        step(3'b000, 3'b000, '0, '0, 3'b001, 1'b0, '0, "R9");
        // R5 and R4: all three at once, machine check wins
        step(3'b111, 3'b101, 32'h300, 32'h2FC, 3'b000, 1'b0, '0, "R5");
        step(3'b000, 3'b000, '0, '0, 3'b100, 1'b0, '0, "R4");
        // R5: critical beats noncritical
        step(3'b011, 3'b001, 32'h400, 32'h3FC, 3'b000, 1'b0, '0, "R5");
        step(3'b000, 3'b000, '0, '0, 3'b010, 1'b0, '0, "R9");
        // R10: entry in the same cycle as a return strobe wins
        step(3'b001, 3'b001, 32'h500, 32'h4FC, 3'b001, 1'b0, '0, "R10");
        // R10: simultaneous return strobes, critical wins over noncritical
        step(3'b000, 3'b000, '0, '0, 3'b011, 1'b0, '0, "R10");
        // R10: write in the same cycle as a return is dropped
        step(3'b000, 3'b000, '0, '0, 3'b001, 1'b1, 32'hDEAD_BEEF, "R10");
        step(3'b000, 3'b000, '0, '0, 3'b000, 1'b1, ALL_EN, "R11");
        // R10: write in the same cycle as an entry is dropped
        step(3'b100, 3'b000, 32'h600, 32'h5FC, 3'b000, 1'b1, 32'h0, "R10");
        step(3'b000, 3'b000, '0, '0, 3'b100, 1'b0, '0, "R9");
        // Mixed pseudo-random traffic against the model: R5 R7 R9 R10
        lf = 32'h1ACE_5EED;
        for (int k = 0; k < 60; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step(lf[2:0] & {3{lf[9]}}, lf[5:3], {lf[31:8], 8'h00}, {lf[23:0], 8'h04},
                 lf[8:6] & {3{~lf[9]}}, lf[10] & lf[11],
                 (lf[12] ? ALL_EN : {lf[31:16], lf[15:0]}), "R5");
        end
        idle("R1");
        idle("R1");
        @(negedge clk);
        while (exp_q.size() > 0) @(negedge clk);
        done = 1;
        report();
    end

endmodule